// File: doc/BRIEF.md
# 8-bit Accumulator Instruction Executor

This block is the execute stage for a small subset of an 8-bit accumulator CPU. A fetch side hands it one opcode together with the byte that follows it in the instruction stream. The block then updates the accumulator, the C register, the four condition flags and the program counter. One clock later it reports how many machine clock cycles the instruction costs.

Four instructions are supported:

- adding an immediate byte to the accumulator;
- decrementing C;
- inverting every bit of the accumulator;
- a relative jump that is taken only while the zero flag is clear.

Each instruction has its own rule for which flags it writes and which it keeps. The jump costs more when it is taken. Any other opcode is reported as illegal and leaves all state as it was.

A one-cycle completion strobe marks the end of each instruction. The executor will not take another opcode while that strobe is high. A read-only 16-bit status word packs the accumulator and the flags for the surrounding logic.

Top module: `exe_core`

## Requirements
- R1: After reset the status word is 0x0000, `reg_c` is 0x00, `pc` equals the RESET_PC parameter (default 0), `done`, `illegal` and `cycles` are 0 and `op_ready` is 1.
- R2: Opcode 0xC6 sets A to (A + arg) mod 256 and clears N. Z is set when the new A is zero. H is set when the low nibbles of A and arg sum to more than 15. The carry flag is set when the full sum exceeds 255. `cycles` reports 8 and pc advances by 2.
- R3: Opcode 0x0D sets C to (C - 1) mod 256 and sets N to 1. Z is set when the new C is zero. H is set when the old low nibble of C was 0. The carry flag and A are unchanged. `cycles` reports 4 and pc advances by 1.
- R4: Opcode 0x2F inverts every bit of A and sets N and H to 1. Z, the carry flag and C are unchanged. `cycles` reports 4 and pc advances by 1.
- R5: Opcode 0x20 with Z clear is taken. pc becomes pc + 2 + the sign-extended 8-bit arg, modulo 2^PC_W, and `cycles` reports 12.
- R6: Opcode 0x20 with Z set is not taken. pc advances by 2 and `cycles` reports 8. Neither form of 0x20 changes A, C or any flag.
- R7: The status word holds A in bits 15:8, Z in bit 7, N in bit 6, H in bit 5 and the carry flag in bit 4. Bits 3:0 are always 0.
- R8: An opcode is accepted on a rising edge where `op_valid` and `op_ready` are both high. `done` is high for exactly the one cycle after acceptance, and `op_ready` is low during that cycle. An opcode offered while `op_ready` is low is ignored.
- R9: Any opcode other than 0xC6, 0x0D, 0x2F and 0x20 raises `illegal` together with `done` and reports `cycles` as 0. It leaves A, C, the flags and pc unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | An opcode is offered |
| op_code | input | 8 | Opcode byte |
| op_arg | input | 8 | Byte following the opcode (immediate or jump offset) |
| op_ready | output | 1 | Executor can accept an opcode this cycle |
| done | output | 1 | One-cycle completion strobe |
| cycles | output | CYC_W | Cycle cost of the finished instruction |
| illegal | output | 1 | Finished opcode was unsupported |
| reg_c | output | 8 | Current value of register C |
| pc | output | PC_W | Program counter |
| status | output | 16 | Packed accumulator and flag word |

## Verification
The assertions check the following on every cycle:

- the completion strobe lasts one cycle and only follows an acceptance;
- an illegal opcode leaves A, C, the flags and pc frozen;
- the complement and the decrement keep the fields they must not touch;
- the 12-cycle cost appears only for a jump taken with Z clear;
- the relative jump never alters A, C or the flags.

The directed scenarios show the arithmetic values themselves. These cover:

- nibble and full carries of the add;
- the accumulator wrapping to zero;
- the decrement of C wrapping from 0x00 to 0xFF;
- backward and forward jump targets.

They also show that an opcode held on the inputs during the busy cycle is dropped.

// File: rtl/exe_pkg.sv
// Package exe_pkg
// Shared opcode values, operation classes, the flag record and the cycle
// costs used by every module of the instruction executor.
package exe_pkg;

    localparam logic [7:0] OPC_ADD_IMM = 8'hC6;
    localparam logic [7:0] OPC_DEC_C   = 8'h0D;
    localparam logic [7:0] OPC_CPL_A   = 8'h2F;
    localparam logic [7:0] OPC_JR_NZ   = 8'h20;

    localparam int COST_SHORT = 4;
    localparam int COST_LONG  = 8;
    localparam int COST_TAKEN = 12;

    typedef enum logic [2:0] {
        CLS_ADD,
        CLS_DEC,
        CLS_CPL,
        CLS_JRNZ,
        CLS_BAD
    } op_cls_e;

    // Packed so that z lands in the highest bit, matching the status word.
    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic cy;
    } flags_t;

endpackage

// File: rtl/exe_decode.sv
// Module exe_decode
// Maps an opcode byte to an operation class and its encoded length.
// Assumes: purely combinational; unknown opcodes map to CLS_BAD.
module exe_decode
    import exe_pkg::*;
(
    input  logic [7:0] opcode,
    output op_cls_e    cls,
    output logic       two_byte
);

    // Classify the opcode and flag the ones that carry a second byte.
    always_comb begin
        cls      = CLS_BAD;
        two_byte = 1'b0;
        case (opcode)
            OPC_ADD_IMM: begin cls = CLS_ADD;  two_byte = 1'b1; end
            OPC_DEC_C:   begin cls = CLS_DEC;  two_byte = 1'b0; end
            OPC_CPL_A:   begin cls = CLS_CPL;  two_byte = 1'b0; end
            OPC_JR_NZ:   begin cls = CLS_JRNZ; two_byte = 1'b1; end
            default:     begin cls = CLS_BAD;  two_byte = 1'b0; end
        endcase
    end

endmodule

// File: rtl/exe_alu.sv
// Module exe_alu
// Computes the next A, C and flags, the branch decision and the cycle cost
// for one operation class.
// Assumes: combinational; for CLS_BAD it returns the inputs and cost 0.
module exe_alu
    import exe_pkg::*;
#(
    parameter int CYC_W = 4
) (
    input  op_cls_e          cls,
    input  logic [7:0]       a_in,
    input  logic [7:0]       c_in,
    input  flags_t           fl_in,
    input  logic [7:0]       arg,
    output logic [7:0]       a_out,
    output logic [7:0]       c_out,
    output flags_t           fl_out,
    output logic             taken,
    output logic [CYC_W-1:0] cost
);

    localparam logic [CYC_W-1:0] C_SHORT = CYC_W'(COST_SHORT);
    localparam logic [CYC_W-1:0] C_LONG  = CYC_W'(COST_LONG);
    localparam logic [CYC_W-1:0] C_TAKEN = CYC_W'(COST_TAKEN);

    logic [8:0] sum9;
    logic [4:0] lo5;
    logic [7:0] c_dec;

    // Full-width and nibble-width sums for the add, and the decremented C.
    always_comb begin
        sum9  = {1'b0, a_in} + {1'b0, arg};
        lo5   = {1'b0, a_in[3:0]} + {1'b0, arg[3:0]};
        c_dec = c_in - 8'd1;
    end

    // Select results, flag effects and cost for the class.
    always_comb begin
        a_out  = a_in;
        c_out  = c_in;
        fl_out = fl_in;
        taken  = 1'b0;
        cost   = '0;
        case (cls)
            CLS_ADD: begin
                a_out     = sum9[7:0];
                fl_out.z  = (sum9[7:0] == 8'h00);
                fl_out.n  = 1'b0;
                fl_out.h  = lo5[4];
                fl_out.cy = sum9[8];
                cost      = C_LONG;
            end
            CLS_DEC: begin
                c_out    = c_dec;
                fl_out.z = (c_dec == 8'h00);
                fl_out.n = 1'b1;
                fl_out.h = (c_in[3:0] == 4'h0);
                cost     = C_SHORT;
            end
            CLS_CPL: begin
                a_out    = ~a_in;
                fl_out.n = 1'b1;
                fl_out.h = 1'b1;
                cost     = C_SHORT;
            end
            CLS_JRNZ: begin
                taken = ~fl_in.z;
                cost  = fl_in.z ? C_LONG : C_TAKEN;
            end
            default: begin
                cost = '0;
            end
        endcase
    end

endmodule

// File: rtl/exe_pc.sv
// Module exe_pc
// Next program counter: steps past the instruction bytes, or jumps
// relative to the stepped value when a branch is taken.
// Assumes: PC_W > 8; an illegal opcode holds the PC.
module exe_pc #(
    parameter int PC_W = 16
) (
    input  logic [PC_W-1:0] pc_in,
    input  logic            legal,
    input  logic            two_byte,
    input  logic            taken,
    input  logic [7:0]      offset,
    output logic [PC_W-1:0] pc_out
);

    localparam int EXT_W = PC_W - 8;

    logic [PC_W-1:0] step;
    logic [PC_W-1:0] seq;
    logic [PC_W-1:0] rel;

    // Instruction length, sequential address and sign-extended offset.
    always_comb begin
        step = two_byte ? PC_W'(2) : PC_W'(1);
        seq  = pc_in + step;
        rel  = {{EXT_W{offset[7]}}, offset};
    end

    // Choose hold, sequential or branch target.
    always_comb begin
        if (!legal)
            pc_out = pc_in;
        else if (taken)
            pc_out = seq + rel;
        else
            pc_out = seq;
    end

endmodule

// File: rtl/exe_core.sv
// Module exe_core
// Execute stage for a four-instruction subset of an 8-bit accumulator CPU.
// It holds A, C, the flags and the PC, accepts one opcode when ready, and
// reports the cost with a one-cycle done strobe.
// Assumes: op_arg is valid with op_code even when the opcode ignores it;
// reset is synchronous and active low.
module exe_core
    import exe_pkg::*;
#(
    parameter int              PC_W     = 16,
    parameter int              CYC_W    = 4,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [7:0]       op_code,
    input  logic [7:0]       op_arg,
    output logic             op_ready,
    output logic             done,
    output logic [CYC_W-1:0] cycles,
    output logic             illegal,
    output logic [7:0]       reg_c,
    output logic [PC_W-1:0]  pc,
    output logic [15:0]      status
);

    logic [7:0]       a_q, c_q;
    flags_t           fl_q;
    logic [PC_W-1:0]  pc_q;
    logic             done_q, ill_q;
    logic [CYC_W-1:0] cyc_q;
    logic             seen_q;

    op_cls_e          cls;
    logic             two_byte;
    logic [7:0]       a_nx, c_nx;
    flags_t           fl_nx;
    logic             taken;
    logic [CYC_W-1:0] cost;
    logic [PC_W-1:0]  pc_nx;
    logic             accept;

    exe_decode u_dec (
        .opcode   (op_code),
        .cls      (cls),
        .two_byte (two_byte)
    );

    exe_alu #(.CYC_W(CYC_W)) u_alu (
        .cls    (cls),
        .a_in   (a_q),
        .c_in   (c_q),
        .fl_in  (fl_q),
        .arg    (op_arg),
        .a_out  (a_nx),
        .c_out  (c_nx),
        .fl_out (fl_nx),
        .taken  (taken),
        .cost   (cost)
    );

    exe_pc #(.PC_W(PC_W)) u_pc (
        .pc_in    (pc_q),
        .legal    (cls != CLS_BAD),
        .two_byte (two_byte),
        .taken    (taken),
        .offset   (op_arg),
        .pc_out   (pc_nx)
    );

    // Handshake: ready except in the cycle of the done strobe.
    always_comb begin
        op_ready = ~done_q;
        accept   = op_valid & op_ready;
    end

    // Architectural state: commit the results of an accepted opcode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q  <= 8'h00;
            c_q  <= 8'h00;
            fl_q <= '0;
            pc_q <= RESET_PC;
        end else if (accept) begin
            a_q  <= a_nx;
            c_q  <= c_nx;
            fl_q <= fl_nx;
            pc_q <= pc_nx;
        end
    end

    // Completion strobe, illegal flag and reported cost.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            ill_q  <= 1'b0;
            cyc_q  <= '0;
        end else begin
            done_q <= accept;
            ill_q  <= accept & (cls == CLS_BAD);
            if (accept)
                cyc_q <= cost;
        end
    end

    // Marks that at least one clock has passed since reset, for the checks.
    always_ff @(posedge clk) begin
        if (!rst_n)
            seen_q <= 1'b0;
        else
            seen_q <= 1'b1;
    end

    // Drive the output ports from the registers.
    always_comb begin
        done    = done_q;
        illegal = ill_q;
        cycles  = cyc_q;
        reg_c   = c_q;
        pc      = pc_q;
        status  = {a_q, fl_q, 4'b0000};
    end

    // R8: done lasts one cycle and only follows an acceptance.
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    p_done_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> $past(accept));

    // R9: an illegal opcode raises done and freezes all state.
    p_illegal_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && ill_q) |-> (done_q && cyc_q == '0 && a_q == $past(a_q)
            && c_q == $past(c_q) && fl_q == $past(fl_q) && pc_q == $past(pc_q)));

    // R4: the complement keeps Z, the carry flag and C.
    p_cpl_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && done_q && $past(cls) == CLS_CPL) |->
            (a_q == ~$past(a_q) && fl_q.n && fl_q.h && fl_q.z == $past(fl_q.z)
             && fl_q.cy == $past(fl_q.cy) && c_q == $past(c_q)));

    // R3: the decrement keeps A and the carry flag.
    p_dec_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && done_q && $past(cls) == CLS_DEC) |->
            (a_q == $past(a_q) && fl_q.cy == $past(fl_q.cy) && fl_q.n));

    // R6: the relative jump touches neither registers nor flags.
    p_jump_no_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && done_q && $past(cls) == CLS_JRNZ) |->
            (a_q == $past(a_q) && c_q == $past(c_q) && fl_q == $past(fl_q)));

    // R5: the taken cost only comes from a jump with Z clear.
    p_taken_cost_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && cyc_q == CYC_W'(COST_TAKEN)) |->
            ($past(cls) == CLS_JRNZ && !$past(fl_q.z)));

endmodule

// File: tb/sim_exe_core.sv
// Directed bench for exe_core: one task per scenario, each checking itself
// against a model kept from the requirements.
module sim_exe_core;

    localparam int PC_W  = 16;
    localparam int CYC_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             op_valid = 1'b0;
    logic [7:0]       op_code = 8'h00;
    logic [7:0]       op_arg = 8'h00;
    logic             op_ready;
    logic             done;
    logic [CYC_W-1:0] cycles;
    logic             illegal;
    logic [7:0]       reg_c;
    logic [PC_W-1:0]  pc;
    logic [15:0]      status;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  ended   = 1'b0;

    // Model of the architectural state.
    logic [7:0]      m_a = 8'h00, m_c = 8'h00;
    logic            m_z = 1'b0, m_n = 1'b0, m_h = 1'b0, m_cy = 1'b0;
    logic [PC_W-1:0] m_pc = '0;

    always #4 clk = ~clk;

    exe_core #(.PC_W(PC_W), .CYC_W(CYC_W)) u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_arg(op_arg), .op_ready(op_ready), .done(done), .cycles(cycles),
        .illegal(illegal), .reg_c(reg_c), .pc(pc), .status(status)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] m_status();
        return {m_a, m_z, m_n, m_h, m_cy, 4'b0000};
    endfunction

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // Offer one opcode at a falling edge; return at the falling edge after acceptance.
    task automatic issue(input logic [7:0] code, input logic [7:0] arg, input bit hold);
        int waits = 0;
        while (!op_ready && waits < 100) begin
            @(negedge clk);
            waits++;
        end
        op_code  = code;
        op_arg   = arg;
        op_valid = 1'b1;
        @(negedge clk);
        if (!hold) op_valid = 1'b0;
    endtask

    task automatic check_after(input string req, input int exp_cyc, input bit exp_ill);
        check({req, " done"},    32'(done),    32'd1);
        check({req, " ready"},   32'(op_ready), 32'd0);
        check({req, " cycles"},  32'(cycles),  32'(exp_cyc));
        check({req, " illegal"}, 32'(illegal), 32'(exp_ill));
        check({req, "/R7 status"}, 32'(status), 32'(m_status()));
        check({req, " reg_c"},   32'(reg_c),   32'(m_c));
        check({req, " pc"},      32'(pc),      32'(m_pc));
    endtask

    task automatic t_reset();
        check("R1 status", 32'(status), 32'h0);
        check("R1 reg_c",  32'(reg_c),  32'h0);
        check("R1 pc",     32'(pc),     32'h0);
        check("R1 done",   32'(done),   32'h0);
        check("R1 illegal",32'(illegal),32'h0);
        check("R1 cycles", 32'(cycles), 32'h0);
        check("R1 ready",  32'(op_ready),32'h1);
    endtask

    task automatic t_add(input logic [7:0] arg);
        logic [8:0] s  = {1'b0, m_a} + {1'b0, arg};
        logic [4:0] lo = {1'b0, m_a[3:0]} + {1'b0, arg[3:0]};
        m_a = s[7:0]; m_z = (s[7:0] == 8'h00); m_n = 1'b0; m_h = lo[4]; m_cy = s[8];
        m_pc = m_pc + PC_W'(2);
        issue(8'hC6, arg, 1'b0);
        check_after("R2", 8, 1'b0);
    endtask

    task automatic t_dec();
        m_h = (m_c[3:0] == 4'h0);
        m_c = m_c - 8'd1;
        m_z = (m_c == 8'h00); m_n = 1'b1;
        m_pc = m_pc + PC_W'(1);
        issue(8'h0D, 8'hA5, 1'b0);
        check_after("R3", 4, 1'b0);
    endtask

    // Complement; with hold set, the opcode stays offered in the busy cycle (R8).
    task automatic t_cpl(input bit hold);
        logic [15:0] st;
        logic [PC_W-1:0] p;
        m_a = ~m_a; m_n = 1'b1; m_h = 1'b1;
        m_pc = m_pc + PC_W'(1);
        issue(8'h2F, 8'h00, hold);
        check_after("R4", 4, 1'b0);
        if (hold) begin
            op_code = 8'hC6;
            op_arg  = 8'h55;
            st = status;
            p  = pc;
            @(negedge clk);
            op_valid = 1'b0;
            check("R8 done low after strobe", 32'(done), 32'd0);
            check("R8 busy offer ignored status", 32'(status), 32'(st));
            check("R8 busy offer ignored pc", 32'(pc), 32'(p));
            check("R8 ready again", 32'(op_ready), 32'd1);
        end
    endtask

    task automatic t_jr(input logic [7:0] off);
        bit tk = !m_z;
        m_pc = m_pc + PC_W'(2) + (tk ? {{(PC_W-8){off[7]}}, off} : '0);
        issue(8'h20, off, 1'b0);
        if (tk) check_after("R5", 12, 1'b0);
        else    check_after("R6", 8, 1'b0);
    endtask

    task automatic t_illegal(input logic [7:0] code);
        issue(code, 8'h3C, 1'b0);
        check_after("R9", 0, 1'b1);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_add(8'h3A);      // no carries
        t_add(8'h08);      // nibble carry only
        t_add(8'hBE);      // wraps to zero: Z, H and carry
        t_cpl(1'b1);       // A = FF, Z and carry kept; busy offer ignored
        t_dec();           // C 00 -> FF, H from nibble borrow
        t_jr(8'hFC);       // taken backward
        t_add(8'h01);      // A FF -> 00, Z set
        t_jr(8'h10);       // not taken
        t_illegal(8'h00);
        t_illegal(8'hFF);
        t_dec();           // C FF -> FE, no borrow
        t_jr(8'h10);       // taken forward
        t_cpl(1'b0);
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule